// File: doc/BRIEF.md
# Ring Oscillator Frequency Calibration Controller

This controller tunes the 8-bit delay control word of a digitally controlled delay line so that the pulse centre frequency the line produces falls inside a target band. During calibration the delay line is closed into a ring oscillator whose frequency is the RF frequency divided by 32. The controller estimates that frequency by counting ring cycles over a fixed number of reference clock cycles. The target band is given as a lower and an upper limit on that count.

The search has two levels. First it picks one of four capacitor-bank settings, working from the slowest bank towards the fastest. Then it settles the six current-starving bits one at a time, starting at the most significant bit, with one measurement per trial. After the last bit it takes one more measurement with the final word and reports whether the count is inside the band. It then drops the ring-mode enable and pulses done. The analog delay cells and the source of the counting window clock are not part of this block.

Top module: `ring_cal_ctrl`

## Requirements
- R1: The control word on `ctrl_o` is {bank[7:6], current[5:0]}. Bank code 0 gives the lowest ring frequency and code 3 the highest. At any fixed bank, a larger current code gives a higher frequency. While reset is asserted, `ctrl_o`, `ring_en_o`, `done_o` and `in_range_o` are all 0.
- R2: A `start_i` seen while idle raises `ring_en_o` on the next clock edge and clears `in_range_o`.
- R3: Each measurement first waits 8 settling cycles. It then counts the rising edges of `ring_i`, passed through a two-flop synchronizer, over exactly `win_len_i` reference cycles.
- R4: The bank search begins at bank 0 with all current bits at 1. If the count is below `cnt_lo_i`, the search moves to the next bank. It stops at the first bank that reaches `cnt_lo_i`, or at bank 3.
- R5: Each current bit, from bit 5 down to bit 0, is first tried at 1 with the lower bits at 0. The bit stays at 1 if the measured count is no greater than `cnt_hi_i`. Otherwise it is cleared.
- R6: After bit 0 is settled, one final measurement is taken with the final word. `in_range_o` becomes 1 only if that count lies within [`cnt_lo_i`, `cnt_hi_i`]. It holds that value until the next accepted start and stays 0 while a run is in progress.
- R7: `done_o` is high for exactly one cycle, in the same cycle that `ring_en_o` falls.
- R8: A `start_i` received while a run is in progress is ignored. The run keeps its result and its length.
- R9: While idle, `ctrl_o` and `in_range_o` hold their values even when the limits change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a calibration run |
| ring_i | input | 1 | Ring oscillator output, asynchronous |
| win_len_i | input | 16 | Counting window in reference cycles |
| cnt_lo_i | input | 16 | Lower limit of the target count |
| cnt_hi_i | input | 16 | Upper limit of the target count |
| ctrl_o | output | 8 | Delay control word {bank, current} |
| ring_en_o | output | 1 | Puts the delay line in ring mode |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| in_range_o | output | 1 | Final count lies inside the limits |

## Verification
The bench's ring model changes its period with the control word, and the window length is a multiple of every period, so each count is exact. The corner cases are these:
- Targets above and below the reachable range. A search that runs past bank 3, or that fails to clear every current bit, would report a wrong word here.
- A band that falls in the gap between two achievable counts. A design that took its verdict from the last trial rather than from a fresh measurement would wrongly report in range.
- Limits that are equal, which test the inclusive comparisons.
- A longer window that moves the chosen bank, catching a window off by one cycle or a counter that ignores the window length.
- A start pulse in the middle of a run. A controller that restarted would take longer.
- A reset in the middle of a run.

// File: rtl/ring_cal_pkg.sv
package ring_cal_pkg;
  typedef enum logic [1:0] {CAL_IDLE, CAL_CAP, CAL_BIT, CAL_FIN} cal_state_e;
  typedef enum logic [1:0] {MTR_IDLE, MTR_SETTLE, MTR_COUNT} mtr_state_e;
endpackage

// File: rtl/ring_edge_sync.sv
module ring_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ring_meter.sv
module ring_meter import ring_cal_pkg::*; #(
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             edge_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [WIN_W-1:0] SETTLE_LAST = WIN_W'(SETTLE_CYC - 1);

  mtr_state_e       st_q;
  logic [WIN_W-1:0] tmr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             win_end;

  // a zero length behaves as one cycle
  assign win_end = ({1'b0, tmr_q} + (WIN_W+1)'(1)) >= {1'b0, win_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= MTR_IDLE;
      tmr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        st_q  <= MTR_SETTLE;
        tmr_q <= '0;
      end else begin
        case (st_q)
          MTR_SETTLE: begin
            if (tmr_q == SETTLE_LAST) begin
              st_q  <= MTR_COUNT;
              tmr_q <= '0;
              cnt_q <= '0;
            end else begin
              tmr_q <= tmr_q + WIN_W'(1);
            end
          end
          MTR_COUNT: begin
            cnt_q <= cnt_q + CNT_W'(edge_i);
            tmr_q <= tmr_q + WIN_W'(1);
            if (win_end) begin
              st_q   <= MTR_IDLE;
              done_q <= 1'b1;
            end
          end
          default: st_q <= MTR_IDLE;
        endcase
      end
    end
  end

  assign done_o  = done_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/cal_search.sv
module cal_search import ring_cal_pkg::*; #(
  parameter int unsigned CAP_W = 2,
  parameter int unsigned CUR_W = 6,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             meas_done_i,
  input  logic [CNT_W-1:0] meas_cnt_i,
  input  logic [CNT_W-1:0] cnt_lo_i,
  input  logic [CNT_W-1:0] cnt_hi_i,
  output logic             meas_go_o,
  output logic [CAP_W-1:0] cap_o,
  output logic [CUR_W-1:0] cur_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             in_range_o
);
  localparam int unsigned      BIT_IW   = (CUR_W > 1) ? $clog2(CUR_W) : 1;
  localparam logic [CAP_W-1:0] CAP_LAST = '1;
  localparam logic [CUR_W-1:0] TOP_MASK = {1'b1, {(CUR_W-1){1'b0}}};

  cal_state_e        st_q;
  logic [CAP_W-1:0]  cap_q;
  logic [CUR_W-1:0]  cur_q;
  logic [BIT_IW-1:0] bit_q;
  logic              go_q, busy_q, done_q, inr_q;

  logic              too_slow, too_fast;
  logic [CUR_W-1:0]  bit_mask, next_mask, kept_cur;

  always_comb begin
    too_slow  = meas_cnt_i < cnt_lo_i;
    too_fast  = meas_cnt_i > cnt_hi_i;
    bit_mask  = CUR_W'(1) << bit_q;
    next_mask = bit_mask >> 1;
    kept_cur  = too_fast ? (cur_q & ~bit_mask) : cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CAL_IDLE;
      cap_q  <= '0;
      cur_q  <= '0;
      bit_q  <= '0;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inr_q  <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (st_q)
        CAL_IDLE: if (start_i) begin
          cap_q  <= '0;
          cur_q  <= '1;
          bit_q  <= BIT_IW'(CUR_W - 1);
          go_q   <= 1'b1;
          busy_q <= 1'b1;
          inr_q  <= 1'b0;
          st_q   <= CAL_CAP;
        end
        CAL_CAP: if (meas_done_i) begin
          go_q <= 1'b1;
          if (too_slow && cap_q != CAP_LAST) begin
            cap_q <= cap_q + CAP_W'(1);
          end else begin
            cur_q <= TOP_MASK;
            st_q  <= CAL_BIT;
          end
        end
        CAL_BIT: if (meas_done_i) begin
          go_q <= 1'b1;
          if (bit_q == '0) begin
            cur_q <= kept_cur;
            st_q  <= CAL_FIN;
          end else begin
            cur_q <= kept_cur | next_mask;
            bit_q <= bit_q - BIT_IW'(1);
          end
        end
        CAL_FIN: if (meas_done_i) begin
          inr_q  <= !too_slow && !too_fast;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          st_q   <= CAL_IDLE;
        end
        default: st_q <= CAL_IDLE;
      endcase
    end
  end

  assign meas_go_o  = go_q;
  assign cap_o      = cap_q;
  assign cur_o      = cur_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign in_range_o = inr_q;
endmodule

// File: rtl/ring_cal_ctrl.sv
module ring_cal_ctrl #(
  parameter int unsigned CAP_W      = 2,
  parameter int unsigned CUR_W      = 6,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned WIN_W      = 16,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned SETTLE_CYC = 8,
  localparam int unsigned CTRL_W    = CAP_W + CUR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ring_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [CNT_W-1:0]  cnt_lo_i,
  input  logic [CNT_W-1:0]  cnt_hi_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              ring_en_o,
  output logic              done_o,
  output logic              in_range_o
);
  logic             ring_rise;
  logic             meas_go, meas_done;
  logic [CNT_W-1:0] meas_cnt;
  logic [CAP_W-1:0] cap;
  logic [CUR_W-1:0] cur;

  ring_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ring_i),
    .rise_o  (ring_rise)
  );

  ring_meter #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (meas_go),
    .edge_i    (ring_rise),
    .win_len_i (win_len_i),
    .done_o    (meas_done),
    .count_o   (meas_cnt)
  );

  cal_search #(.CAP_W(CAP_W), .CUR_W(CUR_W), .CNT_W(CNT_W)) u_search (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .meas_done_i (meas_done),
    .meas_cnt_i  (meas_cnt),
    .cnt_lo_i    (cnt_lo_i),
    .cnt_hi_i    (cnt_hi_i),
    .meas_go_o   (meas_go),
    .cap_o       (cap),
    .cur_o       (cur),
    .busy_o      (ring_en_o),
    .done_o      (done_o),
    .in_range_o  (in_range_o)
  );

  assign ctrl_o = {cap, cur};
endmodule

// File: rtl/ring_cal_checker.sv
module ring_cal_checker #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned CUR_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              ring_en_o,
  input logic              done_o,
  input logic              in_range_o
);
  assert_start_kicks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ring_en_o) |=> (ring_en_o && !in_range_o));

  assert_cap_no_backstep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_en_o && $past(ring_en_o)) |-> (ctrl_o[CTRL_W-1:CUR_W] >= $past(ctrl_o[CTRL_W-1:CUR_W])));

  assert_range_low_in_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_en_o |-> !in_range_o);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_ends_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ring_en_o && $past(ring_en_o)));

  assert_fall_has_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ring_en_o) |-> done_o);

  assert_busy_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_en_o && start_i) |=> (ring_en_o || done_o));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ring_en_o && !start_i) |=> ($stable(ctrl_o) && $stable(in_range_o)));
endmodule

bind ring_cal_ctrl ring_cal_checker #(.CTRL_W(CTRL_W), .CUR_W(CUR_W)) u_ring_cal_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .ctrl_o     (ctrl_o),
  .ring_en_o  (ring_en_o),
  .done_o     (done_o),
  .in_range_o (in_range_o)
);

// File: tb/ring_cal_ctrl_bench.sv
module ring_cal_ctrl_bench;
  localparam int W = 720;
  // ring period in reference cycles per ctrl[7:4]; every entry divides W and W*2
  localparam int PER [16] = '{90, 80, 72, 60, 48, 45, 40, 36, 30, 24, 20, 18, 16, 15, 12, 10};
  // {lo, hi, expected ctrl, expected in_range} at window W
  localparam int VEC [8][4] = '{
    '{16, 20, 'h7F, 1}, '{24, 30, 'h9F, 1}, '{100, 200, 'hFF, 0}, '{1, 5, 'h00, 0},
    '{13, 14, 'h40, 0}, '{45, 50, 'hDF, 1}, '{8, 8, 'h0F, 1},     '{72, 72, 'hFF, 1}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        ring_i = 1'b0;
  logic [15:0] win_len_i = 16'(W);
  logic [15:0] cnt_lo_i = '0;
  logic [15:0] cnt_hi_i = '0;
  logic [7:0]  ctrl_o;
  logic        ring_en_o, done_o, in_range_o;

  int n_chk = 0;
  int n_bad = 0;
  int ph = 0;

  ring_cal_ctrl u_ring_cal_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ring_i(ring_i),
    .win_len_i(win_len_i), .cnt_lo_i(cnt_lo_i), .cnt_hi_i(cnt_hi_i),
    .ctrl_o(ctrl_o), .ring_en_o(ring_en_o), .done_o(done_o), .in_range_o(in_range_o));

  always #2 clk_i = ~clk_i;

  // ring model: faster for larger ctrl[7:4]
  always @(negedge clk_i) begin
    int n, nx;
    if (!ring_en_o) begin
      ph = 0;
      ring_i <= 1'b0;
    end else begin
      n  = PER[ctrl_o[7:4]];
      nx = (ph + 1 >= n) ? 0 : ph + 1;
      ph = nx;
      ring_i <= (nx < n / 2);
    end
  end

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_cal(input int lo, input int hi, input bit poke, output int lat);
    cnt_lo_i = 16'(lo);
    cnt_hi_i = 16'(hi);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check("R2 ring_en after start", int'(ring_en_o), 1);
    check("R2 in_range cleared at start", int'(in_range_o), 0);
    lat = 1;
    while (!done_o && lat < 20000) begin
      @(negedge clk_i);
      lat++;
      start_i = (poke && lat == 300);
    end
    start_i = 1'b0;
    check("R7 done reached", int'(done_o), 1);
    check("R7 ring_en low with done", int'(ring_en_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat_a, lat_b, lat_x;
    repeat (3) @(negedge clk_i);
    check("R1 reset ctrl", int'(ctrl_o), 0);
    check("R1 reset ring_en", int'(ring_en_o), 0);
    check("R1 reset done", int'(done_o), 0);
    check("R1 reset in_range", int'(in_range_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      run_cal(VEC[i][0], VEC[i][1], 1'b0, lat_x);
      check($sformatf("R4 R5 ctrl vector %0d", i), int'(ctrl_o), VEC[i][2]);
      check($sformatf("R6 in_range vector %0d", i), int'(in_range_o), VEC[i][3]);
      @(negedge clk_i);
      check("R7 done one cycle", int'(done_o), 0);
    end

    // R9: new limits while idle change nothing
    cnt_lo_i = 16'd1;
    cnt_hi_i = 16'd2;
    repeat (40) @(negedge clk_i);
    check("R9 ctrl held idle", int'(ctrl_o), 'hFF);
    check("R9 in_range held idle", int'(in_range_o), 1);

    // R3: doubled window shifts the chosen bank
    win_len_i = 16'(2 * W);
    run_cal(36, 40, 1'b0, lat_x);
    check("R3 ctrl with long window", int'(ctrl_o), 'h7F);
    check("R3 in_range with long window", int'(in_range_o), 1);
    win_len_i = 16'(W);
    run_cal(36, 40, 1'b0, lat_x);
    check("R3 ctrl with base window", int'(ctrl_o), 'hBF);

    // R8: mid-run start leaves length and result unchanged
    run_cal(16, 20, 1'b0, lat_a);
    run_cal(16, 20, 1'b1, lat_b);
    check("R8 run length with extra start", lat_b, lat_a);
    check("R8 ctrl with extra start", int'(ctrl_o), 'h7F);

    // R1: reset in the middle of a run
    cnt_lo_i = 16'd45;
    cnt_hi_i = 16'd50;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (200) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run reset ctrl", int'(ctrl_o), 0);
    check("R1 mid-run reset ring_en", int'(ring_en_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    run_cal(24, 30, 1'b0, lat_x);
    check("R4 ctrl after reset recovery", int'(ctrl_o), 'h9F);
    check("R6 in_range after reset recovery", int'(in_range_o), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule